// File: doc/BRIEF.md
# Suspend Modulation Clock Throttler

This block slows a processor core by pulsing its active-low suspend input. It alternates between an asserted phase, in which the core idles, and a released phase, in which the core runs. Each phase lasts a programmable number of ticks. A tick is a fixed interval produced by a prescaler from the input clock, 32 us at the default setting. The core then runs at full speed × released / (released + asserted) on average. With both counts at 255, one asserted stretch lasts about 8 ms.

Software programs the block through a byte-wide register port. It writes the two phase lengths, a configuration byte and two speedup durations in milliseconds. An interrupt or video event, when its speedup is enabled, releases the core at once and stops throttling for the programmed time. When that time has passed, throttling restarts. New phase lengths take effect at the next phase boundary, so a phase that is already running is never cut short.

Top module: `suspmod_throttle`

## Requirements
- R1: After reset all five registers read 0 and `susp_n` is 1 (released).
- R2: Register map: address 0 holds the asserted-phase count, address 1 the released-phase count, address 2 the configuration (bit 0 modulation enable, bit 1 interrupt speedup enable, bit 2 video speedup enable; bits 7:3 read 0), address 3 the interrupt speedup time in ms, and address 4 the video speedup time in ms. Addresses 5 to 7 read 0, and writes to them change nothing.
- R3: While configuration bit 0 is 0, `susp_n` stays 1.
- R4: With modulation enabled, `susp_n` is 0 for exactly asserted-count × TICK_CYC clocks, then 1 for released-count × TICK_CYC clocks, and this repeats. Each phase starts on a tick boundary.
- R5: A phase whose count is 0 is skipped. With a released count of 0 the output stays 0. With an asserted count of 0, or with both counts 0, the output stays 1.
- R6: A count written during a phase does not change the length of that phase. The new value is used the next time its phase is started.
- R7: An `irq_evt` pulse while configuration bit 1 is 1 releases `susp_n` from the second clock after the pulse. The release lasts as long as the interrupt timer is nonzero. That timer is loaded with the register value and counts down once per MS_CYC clocks. With bit 1 clear, the pulse has no effect.
- R8: A `vid_evt` pulse while configuration bit 2 is 1 behaves the same way, using the video time register. With bit 2 clear, the pulse has no effect.
- R9: An enabled event that arrives while its timer is running reloads that timer with the full programmed time.
- R10: Once no timer is running, throttling restarts from the beginning, with an asserted phase at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Suspend request to the core, active low |

## Verification
The hardest situation to reach is an enabled event that arrives while its speedup timer is still running. A retriggered timer looks exactly like a single long release unless the reload comes late enough that the first window would already have ended. The stimulus fires one interrupt, waits most of its window, fires a second one, and then requires the output to stay released well past the point where the first window would have closed. Mid-phase count rewrites and a single zero-length phase are driven as well. A behavioural model predicts `susp_n` on every clock.

// File: rtl/suspmod_pkg.sv
package suspmod_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ON   = 2'd1,
      PH_OFF  = 2'd2
   } phase_e;

   localparam logic [2:0] A_ON_CNT  = 3'd0;
   localparam logic [2:0] A_OFF_CNT = 3'd1;
   localparam logic [2:0] A_CFG     = 3'd2;
   localparam logic [2:0] A_IRQ_MS  = 3'd3;
   localparam logic [2:0] A_VID_MS  = 3'd4;

   localparam int CFG_EN  = 0;
   localparam int CFG_IRQ = 1;
   localparam int CFG_VID = 2;
endpackage

// File: rtl/suspmod_prescale.sv
module suspmod_prescale #(
   parameter int DIV = 1056
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse_o
);
   localparam int W = (DIV < 2) ? 1 : $clog2(DIV);

   if (DIV < 2) begin : g_chk
      $error("suspmod_prescale: DIV must be at least 2");
   end

   logic [W-1:0] cnt_q;

   assign pulse_o = (cnt_q == W'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (pulse_o) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   a_r4_prescale_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> (cnt_q == '0));
endmodule

// File: rtl/suspmod_speedup_timer.sv
module suspmod_speedup_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             en_i,
   input  logic             ms_i,
   input  logic [TMR_W-1:0] load_i,
   output logic             active_o
);
   logic [TMR_W-1:0] left_q;

   assign active_o = (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                left_q <= '0;
      else if (evt_i && en_i)    left_q <= load_i;
      else if (ms_i && active_o) left_q <= left_q - 1'b1;
   end

   a_r9_event_reloads: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i && en_i) |=> (left_q == $past(load_i)));
   a_r7_no_load_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !active_o) |=> !active_o);
endmodule

// File: rtl/suspmod_phase.sv
module suspmod_phase
   import suspmod_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] on_i,
   input  logic [CNT_W-1:0] off_i,
   output logic             assert_o
);
   phase_e           phase_q, nxt_ph;
   logic [CNT_W-1:0] rem_q, nxt_rem;

   always_comb begin
      nxt_ph  = PH_IDLE;
      nxt_rem = '0;
      if (phase_q == PH_ON) begin
         if (off_i != '0)     begin nxt_ph = PH_OFF; nxt_rem = off_i; end
         else if (on_i != '0) begin nxt_ph = PH_ON;  nxt_rem = on_i;  end
      end else begin
         if (on_i != '0)       begin nxt_ph = PH_ON;  nxt_rem = on_i;  end
         else if (off_i != '0) begin nxt_ph = PH_OFF; nxt_rem = off_i; end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         rem_q   <= '0;
      end else if (!run_i) begin
         phase_q <= PH_IDLE;
         rem_q   <= '0;
      end else if (tick_i) begin
         if (phase_q != PH_IDLE && rem_q > CNT_W'(1)) begin
            rem_q <= rem_q - 1'b1;
         end else begin
            phase_q <= nxt_ph;
            rem_q   <= nxt_rem;
         end
      end
   end

   assign assert_o = (phase_q == PH_ON);

   a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick_i) |=> $stable(phase_q));
   a_r5_active_phase_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |-> (rem_q != '0));
endmodule

// File: rtl/suspmod_throttle.sv
module suspmod_throttle
   import suspmod_pkg::*;
#(
   parameter int TICK_CYC = 1056,
   parameter int MS_CYC   = 33000,
   parameter int CNT_W    = 8,
   parameter int TMR_W    = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [2:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       irq_evt,
   input  logic       vid_evt,
   output logic       susp_n
);
   localparam int N_SPD = 2;

   if (CNT_W < 1 || CNT_W > 8 || TMR_W < 1 || TMR_W > 8) begin : g_chk_w
      $error("suspmod_throttle: count widths must be 1..8");
   end
   if (MS_CYC < TICK_CYC) begin : g_chk_ms
      $error("suspmod_throttle: MS_CYC must not be shorter than TICK_CYC");
   end

   logic [CNT_W-1:0] on_q, off_q;
   logic [2:0]       cfg_q;
   logic [TMR_W-1:0] spd_ms_q [N_SPD];
   logic [N_SPD-1:0] evt_v, spd_act;
   logic             tick, ms_pulse, run, on_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= '0;
         off_q <= '0;
         cfg_q <= '0;
         for (int k = 0; k < N_SPD; k++) spd_ms_q[k] <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_ON_CNT:  on_q        <= reg_wdata[CNT_W-1:0];
            A_OFF_CNT: off_q       <= reg_wdata[CNT_W-1:0];
            A_CFG:     cfg_q       <= reg_wdata[2:0];
            A_IRQ_MS:  spd_ms_q[0] <= reg_wdata[TMR_W-1:0];
            A_VID_MS:  spd_ms_q[1] <= reg_wdata[TMR_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_ON_CNT:  reg_rdata = 8'(on_q);
         A_OFF_CNT: reg_rdata = 8'(off_q);
         A_CFG:     reg_rdata = {5'd0, cfg_q};
         A_IRQ_MS:  reg_rdata = 8'(spd_ms_q[0]);
         A_VID_MS:  reg_rdata = 8'(spd_ms_q[1]);
         default:   reg_rdata = '0;
      endcase
   end

   suspmod_prescale #(.DIV(TICK_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .pulse_o(tick));
   suspmod_prescale #(.DIV(MS_CYC)) u_ms (
      .clk(clk), .rst_n(rst_n), .pulse_o(ms_pulse));

   assign evt_v = {vid_evt, irq_evt};

   for (genvar k = 0; k < N_SPD; k++) begin : g_spd
      suspmod_speedup_timer #(.TMR_W(TMR_W)) u_tmr (
         .clk(clk), .rst_n(rst_n),
         .evt_i(evt_v[k]), .en_i(cfg_q[CFG_IRQ + k]),
         .ms_i(ms_pulse), .load_i(spd_ms_q[k]),
         .active_o(spd_act[k]));
   end

   assign run = cfg_q[CFG_EN] && (spd_act == '0);

   suspmod_phase #(.CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
      .on_i(on_q), .off_i(off_q), .assert_o(on_now));

   assign susp_n = !on_now;

   a_r3_disabled_released: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[CFG_EN] |=> susp_n);
   a_r7_irq_speedup_releases: assert property (@(posedge clk) disable iff (!rst_n)
      spd_act[0] |=> susp_n);
   a_r8_vid_speedup_releases: assert property (@(posedge clk) disable iff (!rst_n)
      spd_act[1] |=> susp_n);
endmodule

// File: tb/test_suspmod_throttle.sv
module test_suspmod_throttle;
   localparam int TICK = 4;
   localparam int MS   = 10;

   logic       clk = 0, rst_n = 0;
   logic       reg_wr = 0, irq_evt = 0, vid_evt = 0;
   logic [2:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic       susp_n;

   int    n_tests = 0, n_fail = 0;
   string cur_req = "R1";
   bit    model_on = 0;

   suspmod_throttle #(.TICK_CYC(TICK), .MS_CYC(MS)) i_suspmod_throttle (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_evt(irq_evt),
      .vid_evt(vid_evt), .susp_n(susp_n));

   always #4 clk = ~clk;

   // behavioural reference model
   int m_pt, m_pm, m_st, m_rem, m_on, m_off, m_cfg;
   int m_tl[2], m_ms[2];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pt = 0; m_pm = 0; m_st = 0; m_rem = 0;
         m_on = 0; m_off = 0; m_cfg = 0;
         m_tl = '{0, 0}; m_ms = '{0, 0};
      end else begin
         bit tk, mp, go;
         bit ev[2];
         tk = (m_pt == TICK - 1);
         mp = (m_pm == MS - 1);
         go = m_cfg[0] && m_tl[0] == 0 && m_tl[1] == 0;
         ev[0] = irq_evt; ev[1] = vid_evt;
         if (!go) begin
            m_st = 0; m_rem = 0;
         end else if (tk) begin
            if (m_st != 0 && m_rem > 1) m_rem--;
            else if (m_st == 1) begin
               if (m_off != 0)     begin m_st = 2; m_rem = m_off; end
               else if (m_on != 0) begin m_st = 1; m_rem = m_on; end
               else                begin m_st = 0; m_rem = 0; end
            end else begin
               if (m_on != 0)       begin m_st = 1; m_rem = m_on; end
               else if (m_off != 0) begin m_st = 2; m_rem = m_off; end
               else                 begin m_st = 0; m_rem = 0; end
            end
         end
         for (int k = 0; k < 2; k++) begin
            if (ev[k] && m_cfg[1+k]) m_tl[k] = m_ms[k];
            else if (mp && m_tl[k] > 0) m_tl[k]--;
         end
         m_pt = tk ? 0 : m_pt + 1;
         m_pm = mp ? 0 : m_pm + 1;
         if (reg_wr) begin
            case (reg_addr)
               0: m_on = reg_wdata;
               1: m_off = reg_wdata;
               2: m_cfg = reg_wdata & 7;
               3: m_ms[0] = reg_wdata;
               4: m_ms[1] = reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         n_tests++;
         if (susp_n !== (m_st == 1 ? 1'b0 : 1'b1)) begin
            n_fail++;
            $display("FAIL %s model compare: susp_n=%0b expected=%0b", cur_req,
                     susp_n, (m_st == 1 ? 1'b0 : 1'b1));
         end
      end
   end

   task automatic check(string req, int act, int exp, string what);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd_check(string req, int a, int exp);
      @(negedge clk);
      reg_addr = 3'(a);
      #1;
      check(req, reg_rdata, exp, $sformatf("readback addr %0d", a));
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_low(int n, output int lows);
      lows = 0;
      repeat (n) begin
         @(negedge clk);
         if (susp_n == 1'b0) lows++;
      end
   endtask

   task automatic wait_fall(string req, int lim);
      int i;
      for (i = 0; i < lim; i++) begin
         @(negedge clk);
         if (susp_n == 1'b0) break;
      end
      check(req, (i < lim), 1, "asserted phase starts");
   endtask

   task automatic pulse(bit vid);
      @(negedge clk);
      if (vid) vid_evt = 1; else irq_evt = 1;
      @(negedge clk);
      vid_evt = 0; irq_evt = 0;
   endtask

   task automatic held_high(string req, int n);
      int lows;
      count_low(n, lows);
      check(req, lows, 0, "cycles asserted during speedup");
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int lows;
      repeat (4) @(negedge clk);
      rst_n = 1;
      model_on = 1;
      // R1 reset state
      check("R1", susp_n, 1, "susp_n after reset");
      for (int a = 0; a < 5; a++) rd_check("R1", a, 0);
      // R2 register map
      cur_req = "R2";
      wr(0, 3); wr(1, 2); wr(3, 2); wr(4, 3); wr(2, 8'hF8);
      rd_check("R2", 0, 3); rd_check("R2", 1, 2); rd_check("R2", 2, 0);
      rd_check("R2", 3, 2); rd_check("R2", 4, 3);
      wr(6, 8'h55);
      rd_check("R2", 6, 0); rd_check("R2", 0, 3); rd_check("R2", 1, 2);
      // R3 disabled
      cur_req = "R3";
      count_low(50, lows);
      check("R3", lows, 0, "low cycles while disabled");
      // R4 duty cycle 3 on / 2 off -> 60 of 100
      cur_req = "R4";
      wr(2, 1);
      wait_fall("R4", 40);
      count_low(99, lows);
      check("R4", lows + 1, 60, "low cycles over five periods");
      // R6 rewrite counts mid-phase
      cur_req = "R6";
      wait_fall("R6", 40);
      wr(0, 1); wr(1, 1);
      idle(40);
      wr(0, 4); idle(30);
      // R5 zero-length phases
      cur_req = "R5";
      wr(0, 0); wr(1, 2);
      idle(40);
      count_low(60, lows);
      check("R5", lows, 0, "low cycles with asserted count 0");
      wr(0, 2); wr(1, 0);
      wait_fall("R5", 40);
      count_low(40, lows);
      check("R5", lows, 40, "low cycles with released count 0");
      wr(0, 0); wr(1, 0);
      idle(20);
      count_low(40, lows);
      check("R5", lows, 0, "low cycles with both counts 0");
      // R7 interrupt speedup
      cur_req = "R7";
      wr(0, 3); wr(1, 2); wr(3, 2); wr(2, 3);
      wait_fall("R7", 40);
      pulse(0);
      idle(1);
      held_high("R7", 10);
      idle(30);
      cur_req = "R10";
      wait_fall("R10", 40);
      cur_req = "R7";
      wr(2, 1);
      pulse(0);
      idle(30);
      // R8 video speedup
      cur_req = "R8";
      wait_fall("R8", 40);
      wr(2, 5);
      pulse(1);
      idle(1);
      held_high("R8", 20);
      wr(2, 1);
      pulse(1);
      idle(40);
      // R9 reload while running
      cur_req = "R9";
      wr(2, 3);
      pulse(0);
      idle(11);
      pulse(0);
      idle(1);
      held_high("R9", 10);
      idle(30);
      cur_req = "R10";
      wait_fall("R10", 40);
      idle(20);
      model_on = 0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule